// File: doc/BRIEF.md
# Floppy Controller Powerdown Wake Monitor

This block sits beside the host register window of a PC/AT-style floppy disk controller and tracks whether the controller is powered down. Once powerdown is entered, the block watches each host read or write on the 3-bit register offset. It decides whether that access must bring the controller back up. While the controller sleeps, the block holds the drive-side pin enable low. The host-side decode stays live so that a wake-causing access is still seen.

A write to a control register does not always wake the controller. It wakes only when certain bits in the written byte are set. A motor enable or a reset request in the digital output register wakes it. So does the reset bit in the rate-select register. Any other value written to those registers leaves the controller asleep. A wake is signalled by a single-cycle pulse, and the powerdown flag drops on the clock edge after that pulse.

The controller sequence has three named states. `ST_ACTIVE` means the controller is awake. `ST_ASLEEP` means it is powered down and monitoring accesses. `ST_WAKING` is the single cycle in which the wake pulse is driven. The transitions are:

- `ST_ACTIVE` to `ST_ASLEEP` on a sleep request.
- `ST_ASLEEP` to `ST_WAKING` on a wake-causing access.
- `ST_WAKING` to `ST_ACTIVE` always.

In every other case the state is held.

Top module: `fdc_pd_wake_monitor`

## Requirements
- R1: While `rst_n` is low the block is in `ST_ACTIVE`: `pd_status`=0, `wake_pulse`=0, `drive_if_en`=1.
- R2: In `ST_ACTIVE`, either of two inputs enters powerdown: `pd_enter`=1, or a write to offset 4 with data bit 6 set. After the next clock edge `pd_status`=1 and `drive_if_en`=0.
- R3: While asleep, the following leave the block asleep with no wake pulse: any read or write at offsets 0, 1, 3, 6 or 7, a read at offset 2, and a write at offset 4 with data bit 7 clear. Such a write at offset 4 includes one that sets bit 6.
- R4: While asleep, a read at offset 4 (status) wakes the controller.
- R5: While asleep, a read or a write at offset 5 (data FIFO) wakes the controller.
- R6: While asleep, a write at offset 2 with any of data bits 7:4 (motor enables) set wakes the controller.
- R7: While asleep, either of two writes wakes the controller: a write at offset 2 with data bit 2 = 0 (active-low reset), or a write at offset 4 with data bit 7 = 1 (software reset).
- R8: While asleep, a write at offset 2 with bits 7:4 all 0 and bit 2 = 1 leaves the block asleep, whatever the other bits hold.
- R9: A wake-causing access sampled at edge k makes `wake_pulse` high for exactly the cycle after edge k. `pd_status` clears and `drive_if_en` returns at edge k+1. Accesses sampled at edge k+1 cannot extend or repeat the pulse.
- R10: Accesses made in `ST_ACTIVE` never produce a wake pulse.
- R11: `drive_if_en` is low in every cycle where `pd_status` is high, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_offset | input | 3 | Register offset of the host access |
| rd_stb | input | 1 | Host read strobe, one cycle per access |
| wr_stb | input | 1 | Host write strobe, one cycle per access |
| wr_data | input | 8 | Host write data |
| pd_enter | input | 1 | Direct powerdown entry request |
| pd_status | output | 1 | High while the controller is powered down (including the wake cycle) |
| wake_pulse | output | 1 | One-cycle wake request |
| drive_if_en | output | 1 | Enable for the drive-side interface pins |

## Verification
Every output is a decode of the state register, so each result is due exactly one clock edge after the access that causes it. A wake access sampled at edge k shows `wake_pulse` after edge k. It shows the cleared `pd_status` after edge k+1. The driver applies one access per cycle on the falling edge and queues the outputs expected after the following rising edge. The monitor pops that item one time unit after the rising edge, so every comparison lands in the cycle in which the result is due. Runs of harmless accesses are followed by a wake access in the same sleep period, which shows that the harmless ones left the state untouched.

// File: rtl/fdc_pd_pkg.sv
package fdc_pd_pkg;

    localparam int OFS_W     = 3;
    localparam int DATA_W    = 8;
    localparam int MOTOR_CNT = 4;

    // Register window offsets (behaviour depends on these)
    localparam logic [OFS_W-1:0] OFS_STAT_A  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_STAT_B  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_DRV_OUT = 3'd2;
    localparam logic [OFS_W-1:0] OFS_TAPE    = 3'd3;
    localparam logic [OFS_W-1:0] OFS_STAT_RT = 3'd4;
    localparam logic [OFS_W-1:0] OFS_FIFO    = 3'd5;
    localparam logic [OFS_W-1:0] OFS_SPARE   = 3'd6;
    localparam logic [OFS_W-1:0] OFS_IN_CFG  = 3'd7;

    // Bit positions inside written control bytes
    localparam int DRV_MOTOR_LO  = 4;
    localparam int DRV_RESET_N   = 2;
    localparam int RATE_RESET    = 7;
    localparam int RATE_SLEEP    = 6;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_ASLEEP = 2'd1,
        ST_WAKING = 2'd2
    } pd_state_e;

endpackage

// File: rtl/fdc_pd_access_decode.sv
module fdc_pd_access_decode
    import fdc_pd_pkg::*;
#(
    parameter int P_OFS_W     = OFS_W,
    parameter int P_DATA_W    = DATA_W,
    parameter int P_MOTOR_CNT = MOTOR_CNT
) (
    input  logic [P_OFS_W-1:0]  reg_offset,
    input  logic                rd_stb,
    input  logic                wr_stb,
    input  logic [P_DATA_W-1:0] wr_data,
    input  logic                pd_enter,
    output logic                wake_hit,
    output logic                sleep_req
);

    localparam int MOTOR_HI = DRV_MOTOR_LO + P_MOTOR_CNT - 1;

    logic [P_MOTOR_CNT-1:0] motor_bits;
    logic                   motor_any;

    // Collect the motor enable field of a digital output write
    for (genvar gi = 0; gi < P_MOTOR_CNT; gi++) begin : g_motor
        assign motor_bits[gi] = wr_data[DRV_MOTOR_LO + gi];
    end
    assign motor_any = |motor_bits;

    // Classify the access of this cycle
    always_comb begin
        wake_hit  = 1'b0;
        sleep_req = pd_enter;
        unique case (reg_offset)
            OFS_STAT_RT: begin
                // read: status register, write: rate select
                if (rd_stb) begin
                    wake_hit = 1'b1;
                end
                if (wr_stb) begin
                    if (wr_data[RATE_RESET]) begin
                        wake_hit = 1'b1;
                    end
                    if (wr_data[RATE_SLEEP]) begin
                        sleep_req = 1'b1;
                    end
                end
            end
            OFS_FIFO: begin
                wake_hit = rd_stb | wr_stb;
            end
            OFS_DRV_OUT: begin
                if (wr_stb && (motor_any || !wr_data[DRV_RESET_N])) begin
                    wake_hit = 1'b1;
                end
            end
            default: begin
                wake_hit = 1'b0;
            end
        endcase
    end

    logic unused_hi;
    assign unused_hi = ^{MOTOR_HI};

endmodule

// File: rtl/fdc_pd_state_ctrl.sv
module fdc_pd_state_ctrl
    import fdc_pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wake_hit,
    input  logic sleep_req,
    output logic pd_status,
    output logic wake_pulse,
    output logic drive_if_en
);

    pd_state_e state_q;
    pd_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (sleep_req) begin
                    state_d = ST_ASLEEP;
                end
            end
            ST_ASLEEP: begin
                if (wake_hit) begin
                    state_d = ST_WAKING;
                end
            end
            ST_WAKING: begin
                state_d = ST_ACTIVE;
            end
            default: begin
                state_d = ST_ACTIVE;
            end
        endcase
    end

    // Moore outputs
    always_comb begin
        pd_status   = 1'b0;
        wake_pulse  = 1'b0;
        drive_if_en = 1'b1;
        unique case (state_q)
            ST_ACTIVE: begin
                pd_status   = 1'b0;
                drive_if_en = 1'b1;
            end
            ST_ASLEEP: begin
                pd_status   = 1'b1;
                drive_if_en = 1'b0;
            end
            ST_WAKING: begin
                pd_status   = 1'b1;
                wake_pulse  = 1'b1;
                drive_if_en = 1'b0;
            end
            default: begin
                pd_status   = 1'b0;
                drive_if_en = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fdc_pd_wake_monitor.sv
module fdc_pd_wake_monitor
    import fdc_pd_pkg::*;
#(
    parameter int P_OFS_W  = OFS_W,
    parameter int P_DATA_W = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_OFS_W-1:0]  reg_offset,
    input  logic                rd_stb,
    input  logic                wr_stb,
    input  logic [P_DATA_W-1:0] wr_data,
    input  logic                pd_enter,
    output logic                pd_status,
    output logic                wake_pulse,
    output logic                drive_if_en
);

    logic wake_hit;
    logic sleep_req;

    fdc_pd_access_decode #(
        .P_OFS_W     (P_OFS_W),
        .P_DATA_W    (P_DATA_W),
        .P_MOTOR_CNT (MOTOR_CNT)
    ) u_decode (
        .reg_offset (reg_offset),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .pd_enter   (pd_enter),
        .wake_hit   (wake_hit),
        .sleep_req  (sleep_req)
    );

    fdc_pd_state_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_hit    (wake_hit),
        .sleep_req   (sleep_req),
        .pd_status   (pd_status),
        .wake_pulse  (wake_pulse),
        .drive_if_en (drive_if_en)
    );

endmodule

// File: rtl/fdc_pd_wake_monitor_chk.sv
module fdc_pd_wake_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] reg_offset,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic [7:0] wr_data,
    input logic       pd_enter,
    input logic       pd_status,
    input logic       wake_pulse,
    input logic       drive_if_en
);

    logic asleep;
    logic harmless_ofs;
    assign asleep       = pd_status && !wake_pulse;
    assign harmless_ofs = (reg_offset == 3'd0) || (reg_offset == 3'd1) ||
                          (reg_offset == 3'd3) || (reg_offset == 3'd6) ||
                          (reg_offset == 3'd7);

    // R1: reset state seen at the ports
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (!pd_status && !wake_pulse && drive_if_en)
                else $error("R1 reset state wrong");
        end
    end

    assert_enter_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_status && pd_enter) |=> (pd_status && !drive_if_en));

    assert_harmless_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && harmless_ofs) |=> (pd_status && !wake_pulse));

    assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && rd_stb && reg_offset == 3'd4) |=> wake_pulse);

    assert_fifo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && (rd_stb || wr_stb) && reg_offset == 3'd5) |=> wake_pulse);

    assert_motor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && wr_stb && reg_offset == 3'd2 && (wr_data[7:4] != 4'd0)) |=> wake_pulse);

    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && wr_stb && ((reg_offset == 3'd2 && !wr_data[2]) ||
                              (reg_offset == 3'd4 && wr_data[7]))) |=> wake_pulse);

    assert_quiet_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && wr_stb && !rd_stb && reg_offset == 3'd2 &&
         wr_data[7:4] == 4'd0 && wr_data[2]) |=> (pd_status && !wake_pulse));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> (!wake_pulse && !pd_status && drive_if_en));

    assert_no_wake_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_status |=> !wake_pulse);

    assert_drive_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_status != drive_if_en));

endmodule

bind fdc_pd_wake_monitor fdc_pd_wake_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_offset  (reg_offset),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .wr_data     (wr_data),
    .pd_enter    (pd_enter),
    .pd_status   (pd_status),
    .wake_pulse  (wake_pulse),
    .drive_if_en (drive_if_en)
);

// File: tb/fdc_pd_wake_monitor_test.sv
module fdc_pd_wake_monitor_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_offset = 3'd0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       pd_enter = 1'b0;
    logic       pd_status;
    logic       wake_pulse;
    logic       drive_if_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int mstate = 0;          // 0 active, 1 asleep, 2 waking
    logic [2:0] exp_q[$];    // {pd_status, wake_pulse, drive_if_en}
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_pd_wake_monitor uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_offset  (reg_offset),
        .rd_stb      (rd_stb),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .pd_enter    (pd_enter),
        .pd_status   (pd_status),
        .wake_pulse  (wake_pulse),
        .drive_if_en (drive_if_en)
    );

    // Driver: one access per cycle, expectation for the next rising edge
    task automatic step(input logic rd, input logic wr, input logic [2:0] off,
                        input logic [7:0] d, input logic ent, input string tag);
        bit hit;
        bit slp;
        logic pd;
        @(negedge clk);
        rd_stb = rd; wr_stb = wr; reg_offset = off; wr_data = d; pd_enter = ent;
        hit = (rd && off == 3'd4) || ((rd || wr) && off == 3'd5) ||
              (wr && off == 3'd2 && (d[7:4] != 4'd0 || !d[2])) ||
              (wr && off == 3'd4 && d[7]);
        slp = ent || (wr && off == 3'd4 && d[6]);
        case (mstate)
            0: if (slp) mstate = 1;
            1: if (hit) mstate = 2;
            default: mstate = 0;
        endcase
        pd = (mstate != 0);
        exp_q.push_back({pd, (mstate == 2), ~pd});   // drive enable per R11
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, tag);
    endtask

    task automatic wake_then_idle(input logic rd, input logic wr, input logic [2:0] off,
                                  input logic [7:0] d, input string tag);
        step(rd, wr, off, d, 1'b0, tag);
        idle({tag, "/R9 flag clears"});
    endtask

    // Monitor: compares one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({pd_status, wake_pulse, drive_if_en} !== e) begin
                    fails++;
                    $display("FAIL %s: got pd/wake/en=%b expected %b", t,
                             {pd_status, wake_pulse, drive_if_en}, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #(CLK_PERIOD + 2);
        checks++;
        if ({pd_status, wake_pulse, drive_if_en} !== 3'b001) begin
            fails++;
            $display("FAIL R1: got %b expected 001", {pd_status, wake_pulse, drive_if_en});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R10: wake-type accesses while active do nothing
        step(1'b1, 1'b0, 3'd4, 8'h00, 1'b0, "R10 status read active");
        step(1'b0, 1'b1, 3'd5, 8'h55, 1'b0, "R10 fifo write active");
        step(1'b0, 1'b1, 3'd2, 8'hF0, 1'b0, "R10 motor write active");
        step(1'b0, 1'b1, 3'd4, 8'h80, 1'b0, "R10 rate reset active");

        // R2 by pin; then R3 and R8 harmless accesses; then R4 wake
        step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, "R2 enter by pin");
        for (int o = 0; o < 8; o++) begin
            if (o == 0 || o == 1 || o == 3 || o == 6 || o == 7) begin
                step(1'b1, 1'b0, 3'(o), 8'h00, 1'b0, "R3 harmless read");
                step(1'b0, 1'b1, 3'(o), 8'hFF, 1'b0, "R3 harmless write");
            end
        end
        step(1'b1, 1'b0, 3'd2, 8'h00, 1'b0, "R3 output reg read");
        step(1'b0, 1'b1, 3'd4, 8'h40, 1'b0, "R3 rate write sleep bit only");
        step(1'b0, 1'b1, 3'd4, 8'h3F, 1'b0, "R8 rate write no reset");
        step(1'b0, 1'b1, 3'd2, 8'h04, 1'b0, "R8 output write reset inactive");
        step(1'b0, 1'b1, 3'd2, 8'h0F, 1'b0, "R8 output write low bits");
        step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, "R2 pin while asleep holds");
        wake_then_idle(1'b1, 1'b0, 3'd4, 8'h00, "R4 status read wakes");

        // R2 by rate write; R5 fifo write; R9 second access during pulse
        step(1'b0, 1'b1, 3'd4, 8'h40, 1'b0, "R2 enter by rate write");
        step(1'b0, 1'b1, 3'd5, 8'hA5, 1'b0, "R5 fifo write wakes");
        step(1'b1, 1'b0, 3'd5, 8'h00, 1'b0, "R9 access during pulse");
        idle("R9 stays active");

        // R5 fifo read
        step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, "R2 enter");
        wake_then_idle(1'b1, 1'b0, 3'd5, 8'h00, "R5 fifo read wakes");

        // R6 each motor bit
        for (int b = 4; b < 8; b++) begin
            step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, "R2 enter");
            wake_then_idle(1'b0, 1'b1, 3'd2, 8'(1 << b) | 8'h04, "R6 motor bit wakes");
        end

        // R7 both reset paths
        step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, "R2 enter");
        wake_then_idle(1'b0, 1'b1, 3'd2, 8'h00, "R7 output reset low wakes");
        step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, "R2 enter");
        wake_then_idle(1'b0, 1'b1, 3'd4, 8'h80, "R7 rate reset wakes");
        step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, "R2 enter");
        wake_then_idle(1'b0, 1'b1, 3'd4, 8'hC0, "R7 rate reset with sleep bit");

        idle("R11 final");
        idle("R11 final");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule